// File: doc/BRIEF.md
# Scaled Radix-2 Butterfly Stage

This block is a single radix-2 decimation-in-time butterfly for a fixed-point FFT datapath. Each cycle it can accept two complex data operands, X and Y, and one complex twiddle W. It multiplies Y by W at full precision and forms both X + W·Y and X − W·Y without overflow. It then halves both results and hands on a fixed-width slice of the most significant bits. Halving on every pass keeps the magnitude bounded from stage to stage, so the stage needs no block exponent.

A build parameter picks the stage position. The first stage takes 16-bit Q15 data. Later stages take 24-bit Q23 data. The twiddle is Q15 in both cases, and the output is always a 24-bit slice. The datapath is a free-running three-register pipeline (product, sum/difference, scale/slice). An input strobe travels alongside the data and marks which output cycles carry results. A second parameter chooses between plain truncation and round-half-up for the final slice.

Top module: `bfly_r2_stage`

## Requirements
- R1: A clock edge with `rst` high clears `out_vld` and all four result outputs to zero. `out_vld` stays low for the first three edges after `rst` falls.
- R2: `out_vld` equals `in_vld` as it was three rising edges earlier. The results of a vector appear on the same cycle that its strobe emerges.
- R3: Let S = Xa + P, where Xa is X multiplied by 2^(TW_W−1) and P is the complex product. Each sum output equals floor((S + r) / 2^k). Here k = DATA_W + TW_W + 3 − OUT_W, which gives 11 for 16-bit data and 19 for 24-bit data. The term r is 0 in truncate mode.
- R4: The difference outputs follow the same rule with S = Xa − P. When X is zero, sum + difference lies in {−1, 0, 1} for both the real and the imaginary part.
- R5: The complex product is computed exactly: P_re = Yre·Wre − Yim·Wim and P_im = Yre·Wim + Yim·Wre.
- R6: X is shifted left by TW_W−1 bits so that its binary point lines up with the product's fraction. When W is zero, the sum output equals the difference output.
- R7: The twiddle 0x7FFF, which stands in for unity, follows R3 and R4 exactly, with no special casing.
- R8: The full-scale negative code 0x8000 on any or all inputs yields sign-correct results per R3 and R4, with no wraparound. For example, all six inputs at 0x8000 in the 16-bit stage give sum (−524288, 524288) and difference (−524288, −1572864).
- R9: With `RND_MODE` set to round-half-up, r = 2^(k−1). With truncation, r = 0.
- R10: With `LATE_STAGE` = 1, the data inputs are 24 bits wide and the rules of R3 through R6 apply unchanged, using k = 19.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Marks an input vector |
| x_re | input | DATA_W | X operand, real part |
| x_im | input | DATA_W | X operand, imaginary part |
| y_re | input | DATA_W | Y operand, real part |
| y_im | input | DATA_W | Y operand, imaginary part |
| w_re | input | TW_W | Twiddle, real part, Q15 |
| w_im | input | TW_W | Twiddle, imaginary part, Q15 |
| out_vld | output | 1 | Marks a result, three cycles after `in_vld` |
| sum_re | output | OUT_W | Halved X + W·Y slice, real |
| sum_im | output | OUT_W | Halved X + W·Y slice, imaginary |
| dif_re | output | OUT_W | Halved X − W·Y slice, real |
| dif_im | output | OUT_W | Halved X − W·Y slice, imaginary |

## Verification
All-zero vectors show that nothing leaks out of reset. A zero twiddle isolates the alignment shift of X. A zero X isolates the complex product and its sign handling. The twiddles 0x7FFF and pure-imaginary j separate a swapped cross term or a wrong sign in the product. Vectors made entirely of 0x8000 show whether the product and the adders are wide enough, since they are the only inputs that reach the most positive product. Random vectors, sent back to back and with gaps in the strobe, are run through two configurations: the 16-bit stage with truncation, and the 24-bit stage with rounding. The two configurations distinguish the slice position and the rounding offset.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

   typedef enum logic {
      RND_TRUNC   = 1'b0,
      RND_HALF_UP = 1'b1
   } bfly_rnd_e;

   function automatic int prod_width(input int dw, input int tw);
      return dw + tw;
   endfunction

   function automatic int sum_width(input int dw, input int tw);
      return dw + tw + 2;
   endfunction

endpackage

// File: rtl/bfly_cmul.sv
module bfly_cmul #(
   parameter int DW = 16,
   parameter int TW = 16,
   localparam int PW = bfly_pkg::prod_width(DW, TW)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 vld_i,
   input  logic signed [DW-1:0] x_re_i,
   input  logic signed [DW-1:0] x_im_i,
   input  logic signed [DW-1:0] y_re_i,
   input  logic signed [DW-1:0] y_im_i,
   input  logic signed [TW-1:0] w_re_i,
   input  logic signed [TW-1:0] w_im_i,
   output logic                 vld_o,
   output logic signed [DW-1:0] x_re_o,
   output logic signed [DW-1:0] x_im_o,
   output logic signed [PW-1:0] prod_o [4]
);
   // product slots: 0 = yr*wr, 1 = yi*wi, 2 = yr*wi, 3 = yi*wr
   logic signed [DW-1:0] y_sel [4];
   logic signed [TW-1:0] w_sel [4];
   logic signed [PW-1:0] p_d   [4];

   assign y_sel[0] = y_re_i;
   assign y_sel[1] = y_im_i;
   assign y_sel[2] = y_re_i;
   assign y_sel[3] = y_im_i;
   assign w_sel[0] = w_re_i;
   assign w_sel[1] = w_im_i;
   assign w_sel[2] = w_im_i;
   assign w_sel[3] = w_re_i;

   for (genvar k = 0; k < 4; k++) begin : g_mul
      assign p_d[k] = PW'(y_sel[k]) * PW'(w_sel[k]);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o  <= 1'b0;
         x_re_o <= '0;
         x_im_o <= '0;
         for (int k = 0; k < 4; k++) prod_o[k] <= '0;
      end else begin
         vld_o  <= vld_i;
         x_re_o <= x_re_i;
         x_im_o <= x_im_i;
         for (int k = 0; k < 4; k++) prod_o[k] <= p_d[k];
      end
   end
endmodule

// File: rtl/bfly_addsub.sv
module bfly_addsub #(
   parameter int DW = 16,
   parameter int TW = 16,
   localparam int PW = bfly_pkg::prod_width(DW, TW),
   localparam int CW = PW + 1,
   localparam int SW = bfly_pkg::sum_width(DW, TW)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 vld_i,
   input  logic signed [DW-1:0] x_re_i,
   input  logic signed [DW-1:0] x_im_i,
   input  logic signed [PW-1:0] prod_i [4],
   output logic                 vld_o,
   output logic signed [SW-1:0] res_o  [4]
);
   // result slots: 0 = sum re, 1 = sum im, 2 = diff re, 3 = diff im
   logic signed [CW-1:0] cp  [2];
   logic signed [DW-1:0] xin [2];
   logic signed [SW-1:0] xa  [2];

   assign cp[0]  = CW'(prod_i[0]) - CW'(prod_i[1]);
   assign cp[1]  = CW'(prod_i[2]) + CW'(prod_i[3]);
   assign xin[0] = x_re_i;
   assign xin[1] = x_im_i;

   for (genvar g = 0; g < 2; g++) begin : g_align
      assign xa[g] = SW'($signed({xin[g], {(TW-1){1'b0}}}));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         for (int k = 0; k < 4; k++) res_o[k] <= '0;
      end else begin
         vld_o <= vld_i;
         for (int k = 0; k < 2; k++) begin
            res_o[k]   <= xa[k] + SW'(cp[k]);
            res_o[k+2] <= xa[k] - SW'(cp[k]);
         end
      end
   end
endmodule

// File: rtl/bfly_scale.sv
module bfly_scale #(
   parameter int                  SW  = 34,
   parameter int                  OW  = 24,
   parameter bfly_pkg::bfly_rnd_e RND = bfly_pkg::RND_TRUNC
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 vld_i,
   input  logic signed [SW-1:0] res_i [4],
   output logic                 vld_o,
   output logic signed [OW-1:0] out_o [4]
);
   localparam int DROP = SW - OW;

   logic signed [OW-1:0] sl [4];

   for (genvar k = 0; k < 4; k++) begin : g_lane
      logic signed [SW-1:0] half_v;
      assign half_v = res_i[k] >>> 1;
      if (RND == bfly_pkg::RND_HALF_UP) begin : g_rnd
         localparam logic signed [SW:0] HALF_LSB = (SW+1)'(1) <<< (DROP-1);
         logic signed [SW:0] rv;
         logic               unused_rb;
         assign rv        = (SW+1)'(half_v) + HALF_LSB;
         assign sl[k]     = rv[SW-1 -: OW];
         assign unused_rb = ^{rv[SW], rv[DROP-1:0], half_v[SW-1]};
      end else begin : g_trunc
         logic unused_tb;
         assign sl[k]     = half_v[SW-1 -: OW];
         assign unused_tb = ^half_v[DROP-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o <= 1'b0;
         for (int k = 0; k < 4; k++) out_o[k] <= '0;
      end else begin
         vld_o <= vld_i;
         for (int k = 0; k < 4; k++) out_o[k] <= sl[k];
      end
   end
endmodule

// File: rtl/bfly_r2_stage.sv
module bfly_r2_stage #(
   parameter bit                  LATE_STAGE = 1'b0,
   parameter int                  DATA_W     = LATE_STAGE ? 24 : 16,
   parameter int                  TW_W       = 16,
   parameter int                  OUT_W      = 24,
   parameter bfly_pkg::bfly_rnd_e RND_MODE   = bfly_pkg::RND_TRUNC
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    in_vld,
   input  logic signed [DATA_W-1:0] x_re,
   input  logic signed [DATA_W-1:0] x_im,
   input  logic signed [DATA_W-1:0] y_re,
   input  logic signed [DATA_W-1:0] y_im,
   input  logic signed [TW_W-1:0]   w_re,
   input  logic signed [TW_W-1:0]   w_im,
   output logic                    out_vld,
   output logic signed [OUT_W-1:0]  sum_re,
   output logic signed [OUT_W-1:0]  sum_im,
   output logic signed [OUT_W-1:0]  dif_re,
   output logic signed [OUT_W-1:0]  dif_im
);
   localparam int PW = bfly_pkg::prod_width(DATA_W, TW_W);
   localparam int SW = bfly_pkg::sum_width(DATA_W, TW_W);

   initial begin
      assert (DATA_W == (LATE_STAGE ? 24 : 16))
         else $error("data width does not match stage position");
      assert (TW_W >= 2 && TW_W <= 18) else $error("twiddle width out of range");
      assert (OUT_W >= 2 && OUT_W <= SW - 2) else $error("output slice too wide");
   end

   logic                    v1, v2;
   logic signed [DATA_W-1:0] x1_re, x1_im;
   logic signed [PW-1:0]     prod [4];
   logic signed [SW-1:0]     res  [4];
   logic signed [OUT_W-1:0]  outs [4];

   bfly_cmul #(.DW(DATA_W), .TW(TW_W)) u_cmul (
      .clk(clk), .rst(rst), .vld_i(in_vld),
      .x_re_i(x_re), .x_im_i(x_im), .y_re_i(y_re), .y_im_i(y_im),
      .w_re_i(w_re), .w_im_i(w_im),
      .vld_o(v1), .x_re_o(x1_re), .x_im_o(x1_im), .prod_o(prod)
   );

   bfly_addsub #(.DW(DATA_W), .TW(TW_W)) u_addsub (
      .clk(clk), .rst(rst), .vld_i(v1),
      .x_re_i(x1_re), .x_im_i(x1_im), .prod_i(prod),
      .vld_o(v2), .res_o(res)
   );

   bfly_scale #(.SW(SW), .OW(OUT_W), .RND(RND_MODE)) u_scale (
      .clk(clk), .rst(rst), .vld_i(v2), .res_i(res),
      .vld_o(out_vld), .out_o(outs)
   );

   assign sum_re = outs[0];
   assign sum_im = outs[1];
   assign dif_re = outs[2];
   assign dif_im = outs[3];
endmodule

// File: rtl/bfly_r2_stage_chk.sv
module bfly_r2_stage_chk #(
   parameter int DATA_W = 16,
   parameter int TW_W   = 16,
   parameter int OUT_W  = 24
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    in_vld,
   input logic signed [DATA_W-1:0] x_re,
   input logic signed [DATA_W-1:0] x_im,
   input logic signed [TW_W-1:0]   w_re,
   input logic signed [TW_W-1:0]   w_im,
   input logic                    out_vld,
   input logic signed [OUT_W-1:0]  sum_re,
   input logic signed [OUT_W-1:0]  sum_im,
   input logic signed [OUT_W-1:0]  dif_re,
   input logic signed [OUT_W-1:0]  dif_im
);
   logic [1:0]         since_rst;
   logic signed [OUT_W:0] pair_re, pair_im;

   always_ff @(posedge clk) begin
      if (rst) since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assign pair_re = (OUT_W+1)'(sum_re) + (OUT_W+1)'(dif_re);
   assign pair_im = (OUT_W+1)'(sum_im) + (OUT_W+1)'(dif_im);

   assert_flush_R1: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 2'd3) |-> !out_vld);

   assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> (out_vld == $past(in_vld, 3)));

   assert_zero_twiddle_R6: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && out_vld && $past(w_re == '0 && w_im == '0, 3))
      |-> (sum_re == dif_re && sum_im == dif_im));

   assert_zero_x_R4: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && out_vld && $past(x_re == '0 && x_im == '0, 3))
      |-> (pair_re >= -1 && pair_re <= 1 && pair_im >= -1 && pair_im <= 1));
endmodule

bind bfly_r2_stage bfly_r2_stage_chk #(
   .DATA_W(DATA_W), .TW_W(TW_W), .OUT_W(OUT_W)
) u_chk (
   .clk(clk), .rst(rst), .in_vld(in_vld),
   .x_re(x_re), .x_im(x_im), .w_re(w_re), .w_im(w_im),
   .out_vld(out_vld), .sum_re(sum_re), .sum_im(sum_im),
   .dif_re(dif_re), .dif_im(dif_im)
);

// File: tb/bfly_r2_stage_tb.sv
module bfly_r2_stage_tb;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_vld = 1'b0;
   logic signed [15:0] ex_re, ex_im, ey_re, ey_im, ew_re, ew_im;
   logic signed [23:0] lx_re, lx_im, ly_re, ly_im;
   logic        e_vld, l_vld;
   logic signed [23:0] e_out [4];
   logic signed [23:0] l_out [4];

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   typedef struct {
      int     stamp;
      string  tag;
      longint e_exp [4];
      longint l_exp [4];
   } vec_t;
   vec_t sbq [$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // first stage, truncating
   bfly_r2_stage #(.LATE_STAGE(1'b0)) u_dut (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .x_re(ex_re), .x_im(ex_im), .y_re(ey_re), .y_im(ey_im),
      .w_re(ew_re), .w_im(ew_im), .out_vld(e_vld),
      .sum_re(e_out[0]), .sum_im(e_out[1]), .dif_re(e_out[2]), .dif_im(e_out[3])
   );

   // later stage, rounding (R9, R10)
   bfly_r2_stage #(.LATE_STAGE(1'b1), .RND_MODE(bfly_pkg::RND_HALF_UP)) u_dut_late (
      .clk(clk), .rst(rst), .in_vld(in_vld),
      .x_re(lx_re), .x_im(lx_im), .y_re(ly_re), .y_im(ly_im),
      .w_re(ew_re), .w_im(ew_im), .out_vld(l_vld),
      .sum_re(l_out[0]), .sum_im(l_out[1]), .dif_re(l_out[2]), .dif_im(l_out[3])
   );

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // reference per R3/R4/R5/R6/R9
   function automatic void bref(input longint xr, xi, yr, yi, wr, wi,
                                input int k, input bit rnd, output longint o [4]);
      longint pr, pim, xar, xai, add;
      pr  = yr * wr - yi * wi;
      pim = yr * wi + yi * wr;
      xar = xr * 32768;
      xai = xi * 32768;
      add = rnd ? (longint'(1) <<< (k - 1)) : 0;
      o[0] = (xar + pr  + add) >>> k;
      o[1] = (xai + pim + add) >>> k;
      o[2] = (xar - pr  + add) >>> k;
      o[3] = (xai - pim + add) >>> k;
   endfunction

   task automatic apply(input logic [15:0] xr, xi, yr, yi, wr, wi, input string tag);
      vec_t v;
      ex_re = xr; ex_im = xi; ey_re = yr; ey_im = yi; ew_re = wr; ew_im = wi;
      lx_re = {xr, 8'h5A}; lx_im = {xi, 8'hC3}; ly_re = {yr, 8'h81}; ly_im = {yi, 8'h3F};
      v.stamp = cyc;
      v.tag   = tag;
      bref(longint'(ex_re), longint'(ex_im), longint'(ey_re), longint'(ey_im),
           longint'(ew_re), longint'(ew_im), 11, 1'b0, v.e_exp);
      bref(longint'(lx_re), longint'(lx_im), longint'(ly_re), longint'(ly_im),
           longint'(ew_re), longint'(ew_im), 19, 1'b1, v.l_exp);
      in_vld = 1'b1;
      sbq.push_back(v);
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      in_vld = 1'b0;
      ex_re = 16'sh1234; ey_im = 16'sh7F00;
      repeat (n) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (!rst) begin
         chk("R2", "strobes agree", longint'(l_vld), longint'(e_vld));
         if (e_vld) begin
            if (sbq.size() == 0) begin
               chk("R2", "unexpected out_vld", 1, 0);
            end else begin
               vec_t v;
               v = sbq.pop_front();
               chk({v.tag, " R2"}, "latency", longint'(cyc - v.stamp), 3);
               for (int k = 0; k < 4; k++) begin
                  chk({v.tag, (k < 2) ? " R3" : " R4"}, $sformatf("stage1 out%0d", k),
                      longint'(e_out[k]), v.e_exp[k]);
                  chk({v.tag, " R9 R10"}, $sformatf("late out%0d", k),
                      longint'(l_out[k]), v.l_exp[k]);
               end
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      // R1: busy inputs during reset must not leak out
      ex_re = 16'sh7FFF; ex_im = 16'sh7FFF; ey_re = 16'sh7FFF; ey_im = 16'sh7FFF;
      ew_re = 16'sh7FFF; ew_im = 16'sh7FFF;
      lx_re = '1; lx_im = '1; ly_re = '1; ly_im = '1;
      in_vld = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1", "stage1 out_vld", longint'(e_vld), 0);
      chk("R1", "late out_vld", longint'(l_vld), 0);
      for (int k = 0; k < 4; k++) begin
         chk("R1", "stage1 data", longint'(e_out[k]), 0);
         chk("R1", "late data", longint'(l_out[k]), 0);
      end
      in_vld = 1'b0;
      rst = 1'b0;
      idle(2);

      apply(16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, "R3 zeros");
      apply(16'h4000, 16'hC000, 16'h2000, 16'h1000, 16'h7FFF, 16'h0000, "R7 unity");
      apply(16'h8000, 16'h7FFF, 16'h7FFF, 16'h8000, 16'h7FFF, 16'h0000, "R7 unity edge");
      apply(16'h1234, 16'hEDCC, 16'h7FFF, 16'h8000, 16'h0000, 16'h0000, "R6 zero twiddle");
      apply(16'h0000, 16'h0000, 16'h3456, 16'hABCD, 16'h5A82, 16'hA57E, "R4 zero x");
      apply(16'h0000, 16'h0000, 16'h4000, 16'h2000, 16'h0000, 16'h7FFF, "R5 pure j");
      apply(16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 16'h8000, "R8 all min");
      apply(16'h7FFF, 16'h8000, 16'h8000, 16'h7FFF, 16'h8000, 16'h7FFF, "R8 mixed extremes");
      idle(1);
      apply(16'hFFFF, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h0001, 16'hFFFF, "R9 small");
      idle(3);
      for (int i = 0; i < 150; i++) begin
         apply(16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
               16'($urandom), 16'($urandom), "R5 random");
         if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
      end
      idle(8);
      chk("R2", "scoreboard drained", longint'(sbq.size()), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule